// File: doc/BRIEF.md
# Timer and Counter Configuration Block with I/O Line Allocation

This block keeps the shared settings for a bank of up to six timer channels and two edge counters. It takes one configuration request at a time. A request carries an enable mask with a commit flag, a timer count and counter enables. It also carries a base clock select, an 8-bit divisor, per-channel mode codes and a byte of update and reset strobes. The block drives the timer channels with enables, modes, update pulses and a divided timer tick. It decides which channel owns each physical I/O line. It also counts rising edges for the two counters on their assigned lines.

Every request is answered one cycle later with a response strobe, an error code, an enable status byte and a snapshot of both counters. The snapshot is taken before any reset that the same request asks for. Invalid settings are rejected as a whole, so the configuration can never end up half applied.

Top module: `tc_cfg_alloc`

## Requirements
- R1: The timer count, counter enables, clock base, divisor and modes are written only by a request whose mask bit 7 (commit) is 1. With bit 7 at 0 they keep their previous values, and reserved codes in those fields raise no error.
- R2: Mask bits 2:0 give the number of enabled timers, bit 3 enables counter 0 and bit 4 enables counter 1. In `status_o`, bit i (i from 0 to 5) is 1 when timer i is enabled, bit 6 is the counter 0 enable and bit 7 is the counter 1 enable.
- R3: Enabled timers take lines 0 upward in order, then enabled counters take the next lines, counter 0 first. The source id of each used line is the timer number for a timer, 6 for counter 0 and 7 for counter 1. Used lines are always contiguous from line 0.
- R4: A counter is cleared when a committed request changes its enable. A counter whose enable does not change keeps its count.
- R5: In `upd_rst_i`, bit i (0 to 5) produces a one-cycle pulse on `tmr_upd_o[i]` in the cycle after the request, and a committed request pulses every timer. Bit 6 clears counter 0 and bit 7 clears counter 1.
- R6: `rsp_valid_o` is 1 in the cycle after each request. `cnt_cap_o` then holds the counter values from before any clear made by that request. Counter 0 is in the low field.
- R7: Clock base code 0 gives a base tick every 64 system cycles (750 kHz from 48 MHz). Code 1 gives a base tick every cycle. The tick period is the divisor times the base period, and a divisor of 0 counts as 256.
- R8: A committed request with a timer count above 6 returns error 1, and one with a clock base code of 2 or 3 returns error 2. Such a request changes no configuration and no counter, and emits no strobe. A valid request returns error 0.
- R9: An enabled counter adds one for each rising edge on its line, seen after a two-flop synchronizer, and wraps past its maximum value.
- R10: `tick_o` is a single-cycle enable pulse in the system clock domain, unless the tick period is one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, one cycle per request |
| en_mask_i | input | 8 | Commit flag (bit 7), counter enables (bits 4:3), timer count (bits 2:0) |
| clk_base_i | input | 2 | Base clock select: 0 slow, 1 system clock, 2 and 3 reserved |
| div_i | input | 8 | Tick divisor, 0 means 256 |
| upd_rst_i | input | 8 | Timer update strobes (bits 5:0) and counter clears (bits 7:6) |
| tmr_mode_i | input | 24 | Four-bit mode code per timer, timer 0 in the low bits |
| io_i | input | 8 | Physical I/O line levels |
| tick_o | output | 1 | Divided timer tick enable |
| tmr_en_o | output | 6 | Timer enables |
| tmr_mode_o | output | 24 | Committed timer modes |
| tmr_upd_o | output | 6 | Timer update and reset pulses |
| line_used_o | output | 8 | Line is owned by a channel |
| line_src_o | output | 24 | Three-bit source id per line, line 0 in the low bits |
| rsp_valid_o | output | 1 | Response strobe |
| err_o | output | 2 | Error code of the last request |
| status_o | output | 8 | Enable status |
| cnt_cap_o | output | 64 | Counter snapshot, counter 0 in the low bits |

## Verification
On every cycle the assertions check that rejected and uncommitted requests leave the configuration untouched, and that rejected requests emit no strobes. They also check that the line map stays contiguous and matches the enable count, that an idle counter reads zero, that a clear takes effect on the next cycle, and that the tick is a single-cycle pulse. Only the bench's scenarios can show the actual tick periods for each base and divisor, and the exact packing of mixed timers and counters. The same holds for the capture-before-clear order, the preservation of a counter whose enable did not change, and counter wrap.

// File: rtl/tc_cfg_pkg.sv
package tc_cfg_pkg;
  localparam int MASK_W  = 8;
  localparam int UPD_BIT = 7;
  localparam int TCNT_W  = 3;
  localparam int CEN_LSB = 3;
  localparam int DIV_W   = 8;

  localparam logic [1:0] BASE_SLOW = 2'd0;
  localparam logic [1:0] BASE_SYS  = 2'd1;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_TCNT = 2'd1,
    ERR_BASE = 2'd2
  } err_e;
endpackage

// File: rtl/tc_clk_div.sv
module tc_clk_div #(
  parameter int BASE_PRE = 64,
  parameter int DIV_W    = 8,
  localparam int PRE_W   = (BASE_PRE > 1) ? $clog2(BASE_PRE) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             fast_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_cnt_q;
  logic [DIV_W-1:0] lim;
  logic             base_tick;

  // zero wraps to all ones: divide by 2**DIV_W
  assign lim       = div_i - DIV_W'(1);
  assign base_tick = fast_i || (pre_q == PRE_W'(BASE_PRE - 1));
  assign tick_o    = base_tick && (div_cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q     <= '0;
      div_cnt_q <= '0;
    end else if (restart_i) begin
      pre_q     <= '0;
      div_cnt_q <= '0;
    end else begin
      pre_q <= (pre_q == PRE_W'(BASE_PRE - 1)) ? '0 : pre_q + PRE_W'(1);
      if (base_tick) div_cnt_q <= tick_o ? '0 : div_cnt_q + DIV_W'(1);
    end
  end

  AST_TICK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !restart_i && lim != '0) |=> !tick_o) else $error("tick wider than one cycle"); // R10
endmodule

// File: rtl/tc_pin_map.sv
module tc_pin_map #(
  parameter int N_TMR   = 6,
  parameter int N_CNT   = 2,
  parameter int TW      = 3,
  localparam int N_LINES = N_TMR + N_CNT,
  localparam int SRC_W   = $clog2(N_LINES)
) (
  input  logic [TW-1:0]          ntmr_i,
  input  logic [N_CNT-1:0]       cen_i,
  output logic [N_LINES-1:0]     used_o,
  output logic [N_LINES*SRC_W-1:0] src_o,
  output logic [N_CNT*SRC_W-1:0] cnt_line_o
);
  always_comb begin
    int pos;
    cnt_line_o = '0;
    used_o     = '0;
    src_o      = '0;
    for (int k = 0; k < N_CNT; k++) begin
      pos = int'(ntmr_i);
      for (int j = 0; j < k; j++) if (cen_i[j]) pos++;
      cnt_line_o[k*SRC_W +: SRC_W] = SRC_W'(pos);
    end
    for (int l = 0; l < N_TMR; l++) begin
      if (l < int'(ntmr_i)) begin
        used_o[l]              = 1'b1;
        src_o[l*SRC_W +: SRC_W] = SRC_W'(l);
      end
    end
    for (int k = 0; k < N_CNT; k++) begin
      if (cen_i[k]) begin
        used_o[cnt_line_o[k*SRC_W +: SRC_W]] = 1'b1;
        src_o[int'(cnt_line_o[k*SRC_W +: SRC_W])*SRC_W +: SRC_W] = SRC_W'(N_TMR + k);
      end
    end
  end

  for (genvar l = 0; l < N_LINES - 1; l++) begin : g_pack_chk
    always_comb begin
      AST_LINES_PACKED: assert (!(used_o[l+1] && !used_o[l])) else $error("line gap"); // R3
    end
  end

  always_comb begin
    AST_LINE_COUNT: assert ($countones(used_o) == int'(ntmr_i) + $countones(cen_i)) else $error("line count"); // R3
  end
endmodule

// File: rtl/tc_edge_cnt.sv
module tc_edge_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             pin_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [1:0]       sync_q;
  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      prev_q <= sync_q[1];
      if (clr_i)                             cnt_q <= '0;
      else if (en_i && sync_q[1] && !prev_q) cnt_q <= cnt_q + CNT_W'(1); // wraps
    end
  end

  assign cnt_o = cnt_q;

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> cnt_q == '0) else $error("disabled counter nonzero"); // R4
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0) else $error("clear missed"); // R5
endmodule

// File: rtl/tc_cfg_alloc.sv
module tc_cfg_alloc
  import tc_cfg_pkg::*;
#(
  parameter int N_TMR    = 6,
  parameter int N_CNT    = 2,
  parameter int CNT_W    = 32,
  parameter int MODE_W   = 4,
  parameter int BASE_PRE = 64,
  localparam int N_LINES = N_TMR + N_CNT,
  localparam int SRC_W   = $clog2(N_LINES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic [MASK_W-1:0]         en_mask_i,
  input  logic [1:0]                clk_base_i,
  input  logic [DIV_W-1:0]          div_i,
  input  logic [N_LINES-1:0]        upd_rst_i,
  input  logic [N_TMR*MODE_W-1:0]   tmr_mode_i,
  input  logic [N_LINES-1:0]        io_i,
  output logic                      tick_o,
  output logic [N_TMR-1:0]          tmr_en_o,
  output logic [N_TMR*MODE_W-1:0]   tmr_mode_o,
  output logic [N_TMR-1:0]          tmr_upd_o,
  output logic [N_LINES-1:0]        line_used_o,
  output logic [N_LINES*SRC_W-1:0]  line_src_o,
  output logic                      rsp_valid_o,
  output logic [1:0]                err_o,
  output logic [N_LINES-1:0]        status_o,
  output logic [N_CNT*CNT_W-1:0]    cnt_cap_o
);
  logic [TCNT_W-1:0]       req_ntmr;
  logic                    commit;
  err_e                    err_d;
  logic                    act, apply;

  logic [TCNT_W-1:0]       ntmr_q;
  logic [N_CNT-1:0]        cen_q;
  logic                    fast_q;
  logic [DIV_W-1:0]        div_q;
  logic [N_TMR*MODE_W-1:0] mode_q;

  logic                    rsp_valid_q;
  err_e                    err_q;
  logic [N_TMR-1:0]        upd_q;
  logic [N_CNT*CNT_W-1:0]  cap_q;
  logic [N_CNT*CNT_W-1:0]  cnt_all;
  logic [N_CNT*SRC_W-1:0]  cnt_line;

  logic unused_mask;
  assign unused_mask = ^en_mask_i[UPD_BIT-1:CEN_LSB+N_CNT];

  assign req_ntmr = en_mask_i[TCNT_W-1:0];
  assign commit   = en_mask_i[UPD_BIT];

  always_comb begin
    err_d = ERR_NONE;
    if (commit) begin
      if (int'(req_ntmr) > N_TMR)  err_d = ERR_TCNT;
      else if (clk_base_i[1])      err_d = ERR_BASE;
    end
  end

  assign act   = req_i && (err_d == ERR_NONE);
  assign apply = act && commit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ntmr_q <= '0;
      cen_q  <= '0;
      fast_q <= 1'b0;
      div_q  <= '0;
      mode_q <= '0;
    end else if (apply) begin
      ntmr_q <= req_ntmr;
      cen_q  <= en_mask_i[CEN_LSB +: N_CNT];
      fast_q <= (clk_base_i == BASE_SYS);
      div_q  <= div_i;
      mode_q <= tmr_mode_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      err_q       <= ERR_NONE;
      upd_q       <= '0;
      cap_q       <= '0;
    end else begin
      rsp_valid_q <= req_i;
      upd_q       <= act ? (upd_rst_i[N_TMR-1:0] | {N_TMR{apply}}) : '0;
      if (req_i) begin
        err_q <= err_d;
        cap_q <= cnt_all;  // snapshot precedes any clear at this edge
      end
    end
  end

  tc_clk_div #(.BASE_PRE(BASE_PRE), .DIV_W(DIV_W)) u_clk_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (apply),
    .fast_i    (fast_q),
    .div_i     (div_q),
    .tick_o    (tick_o)
  );

  tc_pin_map #(.N_TMR(N_TMR), .N_CNT(N_CNT), .TW(TCNT_W)) u_pin_map (
    .ntmr_i     (ntmr_q),
    .cen_i      (cen_q),
    .used_o     (line_used_o),
    .src_o      (line_src_o),
    .cnt_line_o (cnt_line)
  );

  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
    logic clr, pin;
    assign clr = act && (upd_rst_i[N_TMR+k] ||
                         (commit && (en_mask_i[CEN_LSB+k] != cen_q[k])));
    assign pin = io_i[cnt_line[k*SRC_W +: SRC_W]];
    tc_edge_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (cen_q[k]),
      .clr_i  (clr),
      .pin_i  (pin),
      .cnt_o  (cnt_all[k*CNT_W +: CNT_W])
    );
  end

  for (genvar i = 0; i < N_TMR; i++) begin : g_ten
    assign tmr_en_o[i] = int'(ntmr_q) > i;
  end

  assign tmr_mode_o  = mode_q;
  assign tmr_upd_o   = upd_q;
  assign rsp_valid_o = rsp_valid_q;
  assign err_o       = err_q;
  assign status_o    = {cen_q, tmr_en_o};
  assign cnt_cap_o   = cap_q;

  AST_GATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !commit) |=> ($stable(ntmr_q) && $stable(cen_q) && $stable(fast_q)
                            && $stable(div_q) && $stable(mode_q))) else $error("uncommitted write"); // R1
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && commit && (int'(req_ntmr) > N_TMR || clk_base_i[1])) |=>
      ($stable(ntmr_q) && $stable(cen_q) && $stable(fast_q) && $stable(div_q)
       && $stable(mode_q) && tmr_upd_o == '0)) else $error("rejected request took effect"); // R8
  AST_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o) else $error("missing response"); // R6
  AST_NTMR_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ntmr_q) <= N_TMR) else $error("illegal timer count"); // R8
endmodule

// File: tb/tc_cfg_alloc_tb.sv
module tc_cfg_alloc_tb;
  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [7:0]  mask = '0;
  logic [1:0]  base = '0;
  logic [7:0]  div = '0;
  logic [7:0]  ur = '0;
  logic [23:0] mode = '0;
  logic [7:0]  io = '0;

  logic        tick;
  logic [5:0]  tmr_en, tmr_upd;
  logic [23:0] tmr_mode;
  logic [7:0]  used;
  logic [23:0] src;
  logic        rsp_valid;
  logic [1:0]  err;
  logic [7:0]  status;
  logic [2*CW-1:0] cap;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tc_cfg_alloc #(.CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .en_mask_i(mask),
    .clk_base_i(base), .div_i(div), .upd_rst_i(ur), .tmr_mode_i(mode),
    .io_i(io), .tick_o(tick), .tmr_en_o(tmr_en), .tmr_mode_o(tmr_mode),
    .tmr_upd_o(tmr_upd), .line_used_o(used), .line_src_o(src),
    .rsp_valid_o(rsp_valid), .err_o(err), .status_o(status), .cnt_cap_o(cap)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [7:0] m, input logic [1:0] b, input logic [7:0] d,
                        input logic [7:0] u, input logic [23:0] md);
    @(negedge clk);
    req = 1'b1; mask = m; base = b; div = d; ur = u; mode = md;
    @(negedge clk);
    req = 1'b0; ur = '0;
  endtask

  task automatic pulse(input int line, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); io[line] = 1'b1;
      repeat (3) @(negedge clk);
      io[line] = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R2", "status after reset", status, 8'h00);
    chk("R3", "used after reset", used, 8'h00);
    chk("R6", "rsp_valid after reset", rsp_valid, 0);
    chk("R8", "err after reset", err, 0);
  endtask

  task automatic t_config;
    do_req(8'h92, 2'd1, 8'd4, 8'h00, 24'h123456);
    chk("R6", "rsp_valid", rsp_valid, 1);
    chk("R2", "status 2 timers + c1", status, 8'h83);
    chk("R3", "used lines", used, 8'h07);
    chk("R3", "line0 src", src[2:0], 0);
    chk("R3", "line1 src", src[5:3], 1);
    chk("R3", "line2 src c1", src[8:6], 7);
    chk("R1", "modes committed", tmr_mode, 24'h123456);
    chk("R5", "commit pulses all timers", tmr_upd, 6'h3F);
    chk("R8", "valid err", err, 0);
    @(negedge clk);
    chk("R6", "rsp_valid single", rsp_valid, 0);
  endtask

  task automatic t_gate;
    do_req(8'h0F, 2'd3, 8'd9, 8'h00, 24'hFFFFFF);
    chk("R1", "status held", status, 8'h83);
    chk("R1", "modes held", tmr_mode, 24'h123456);
    chk("R1", "no error uncommitted", err, 0);
    chk("R1", "line map held", used, 8'h07);
  endtask

  task automatic t_count;
    pulse(2, 5);
    do_req(8'h00, 2'd0, 8'd0, 8'h00, 24'h0);
    chk("R9", "c1 counted 5", cap[2*CW-1:CW], 5);
    chk("R9", "c0 idle", cap[CW-1:0], 0);
    do_req(8'h00, 2'd0, 8'd0, 8'h80, 24'h0);
    chk("R6", "capture before clear", cap[2*CW-1:CW], 5);
    do_req(8'h00, 2'd0, 8'd0, 8'h00, 24'h0);
    chk("R5", "c1 cleared by bit7", cap[2*CW-1:CW], 0);
  endtask

  task automatic t_pack;
    pulse(2, 4);
    do_req(8'h9B, 2'd1, 8'd4, 8'h00, 24'h123456);
    chk("R2", "status 3 timers both counters", status, 8'hC7);
    chk("R3", "used 5 lines", used, 8'h1F);
    chk("R3", "line3 src c0", src[11:9], 6);
    chk("R3", "line4 src c1", src[14:12], 7);
    pulse(3, 2);
    do_req(8'h00, 2'd0, 8'd0, 8'h00, 24'h0);
    chk("R9", "c0 on line3", cap[CW-1:0], 2);
    chk("R4", "c1 kept across commit", cap[2*CW-1:CW], 4);
    do_req(8'h93, 2'd1, 8'd4, 8'h00, 24'h123456);
    chk("R3", "c1 moves to line3", src[11:9], 7);
    do_req(8'h9B, 2'd1, 8'd4, 8'h00, 24'h123456);
    do_req(8'h00, 2'd0, 8'd0, 8'h00, 24'h0);
    chk("R4", "c0 cleared by toggle", cap[CW-1:0], 0);
    chk("R4", "c1 untouched", cap[2*CW-1:CW], 4);
  endtask

  task automatic t_err;
    do_req(8'h87, 2'd1, 8'd2, 8'h3F, 24'h0);
    chk("R8", "count 7 error", err, 1);
    chk("R8", "status unchanged", status, 8'hC7);
    chk("R8", "no strobe on error", tmr_upd, 0);
    chk("R8", "modes unchanged", tmr_mode, 24'h123456);
    do_req(8'h83, 2'd2, 8'd2, 8'h00, 24'h0);
    chk("R8", "reserved base error", err, 2);
    chk("R8", "status unchanged base", status, 8'hC7);
    do_req(8'h00, 2'd0, 8'd0, 8'h00, 24'h0);
    chk("R8", "error clears", err, 0);
    chk("R4", "c1 survives rejects", cap[2*CW-1:CW], 4);
  endtask

  task automatic t_strobe;
    do_req(8'h00, 2'd0, 8'd0, 8'h05, 24'h0);
    chk("R5", "strobe timers 0,2", tmr_upd, 6'h05);
    @(negedge clk);
    chk("R5", "strobe one cycle", tmr_upd, 0);
  endtask

  task automatic t_div(input logic [1:0] b, input logic [7:0] d, input int exp_per);
    int n;
    int guard;
    do_req(8'h9B, b, d, 8'h00, 24'h123456);
    guard = 0;
    while (!tick && guard < 1000) begin @(negedge clk); guard++; end
    @(negedge clk);
    chk("R10", "tick width one", tick, 0);
    n = 1;
    while (!tick && n < 1000) begin @(negedge clk); n++; end
    chk("R7", $sformatf("period base%0d div%0d", b, d), n, exp_per);
  endtask

  task automatic t_wrap;
    pulse(3, 258);
    do_req(8'h00, 2'd0, 8'd0, 8'h00, 24'h0);
    chk("R9", "c0 wraps 258 mod 256", cap[CW-1:0], 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_gate();
    t_count();
    t_pack();
    t_err();
    t_strobe();
    t_div(2'd1, 8'd4, 4);
    t_div(2'd1, 8'd0, 256);
    t_div(2'd0, 8'd1, 64);
    t_div(2'd0, 8'd2, 128);
    t_wrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule